// File: doc/BRIEF.md
# Programmable-Priority Interrupt Controller

The block gathers 32 fixed-position request lines and drives two processor interrupt outputs: a normal one (IRQ) and a fast one (FIQ). A per-line route bit sends the line's hardware request to one output. The same line's software request bit then feeds the other output, so every line offers exactly one candidate to each output. Hardware-path and software-path candidates each have their own 5-bit priority register. A lower value wins. Among equal values, the lowest line number wins.

Each output has its own arbiter. The arbiter looks at all pending, unmasked candidates and registers the winner once per clock as a vector word. The vector word holds an active flag and the winning line number. Software programs the block through a plain synchronous port. A write takes effect at the clock edge. A read returns the selected register combinationally. Per-line masks apply to both paths of a line. A separate block bit for each output silences that output as a whole.

Top module: `pic_prio_ctrl`

## Requirements
- R1: After reset, the route register reads 0x0FFFFFFF, every per-line mask bit is set (masked), all software requests are clear, both block bits are clear, every priority reads 0, and both outputs are low.
- R2: Word offsets are as follows. 0x00 is the route register (read/write). 0x04 is mask-set and 0x08 is mask-clear: writing 1 to a bit sets or clears that line's mask, and both offsets read back the mask. 0x0C holds the block bits (bit 0 for IRQ, bit 1 for FIQ). 0x10 is software-set and 0x14 is software-clear; both read back the software request bits. 0x18 is the IRQ vector and 0x1C is the FIQ vector.
- R3: Hardware-path priority of line i is at 0x40+4·i. Software-path priority of line i is at 0xC0+4·i. Only bits 4:0 are stored, and they read back zero-extended.
- R4: Among candidates with the same priority value, the one on the lowest-numbered line wins.
- R5: A route bit of 1 sends the line's hardware request to IRQ (with hardware priority) and its software request to FIQ (with software priority). A route bit of 0 does the reverse.
- R6: A line with its mask bit set offers no candidate to either output.
- R7: Block bit 0 holds the IRQ output low and its vector at zero. Block bit 1 does the same for FIQ. Block bits never change the per-line masks, and they read back independently of them.
- R8: Vector word layout: bit 5 is the active flag and bits 4:0 are the winning line. The word is zero when no candidate exists. Each output equals bit 5 of its vector. The vector reflects requests and registers one clock edge later.
- R9: Hardware requests are level-sensitive. A software request stays set until a software-clear write removes it.
- R10: Writes to the vector offsets have no effect. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 32 | Level-sensitive hardware request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 9 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the register at addr |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
A corrupted route, mask or priority bit shows up as a wrong line number or a wrong active flag in a vector word. This happens at the first clock edge after the request pattern that exposes it. A table of request, route and mask patterns is chosen so that each configuration makes a different line win. Each winner is chosen for one reason: a tie, a priority, a route or a mask. A stuck software request or block bit shows up as an output that stays high, or stays low, one cycle after the write that should change it.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int unsigned PIC_DW     = 32;
   localparam int unsigned VEC_W      = 6;
   localparam int unsigned VEC_ACT    = 5;
   localparam int unsigned OFS_ROUTE  = 'h00;
   localparam int unsigned OFS_MSET   = 'h04;
   localparam int unsigned OFS_MCLR   = 'h08;
   localparam int unsigned OFS_BLOCK  = 'h0C;
   localparam int unsigned OFS_SWSET  = 'h10;
   localparam int unsigned OFS_SWCLR  = 'h14;
   localparam int unsigned OFS_IVEC   = 'h18;
   localparam int unsigned OFS_FVEC   = 'h1C;
   localparam int unsigned OFS_PHW    = 'h40;

   typedef enum logic [3:0] {
      RS_NONE, RS_ROUTE, RS_MSET, RS_MCLR, RS_BLOCK,
      RS_SWSET, RS_SWCLR, RS_IVEC, RS_FVEC, RS_PHW, RS_PSW
   } pic_rsel_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
   import pic_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 5,
   parameter int unsigned ADDR_W = 9,
   parameter logic [N_SRC-1:0] ROUTE_RST = N_SRC'(32'h0FFF_FFFF)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [PIC_DW-1:0]             wdata,
   input  logic [VEC_W-1:0]              irq_vec_i,
   input  logic [VEC_W-1:0]              fiq_vec_i,
   output logic [PIC_DW-1:0]             rdata,
   output logic [N_SRC-1:0]              route_q,
   output logic [N_SRC-1:0]              mask_q,
   output logic [N_SRC-1:0]              sw_q,
   output logic [1:0]                    block_q,
   output logic [N_SRC-1:0][PRIO_W-1:0]  prio_hw_q,
   output logic [N_SRC-1:0][PRIO_W-1:0]  prio_sw_q
);
   localparam int unsigned IDX_W  = $clog2(N_SRC);
   localparam int unsigned HW_LO  = OFS_PHW;
   localparam int unsigned SW_LO  = OFS_PHW + 4 * N_SRC;
   localparam int unsigned SW_HI  = OFS_PHW + 8 * N_SRC;

   pic_rsel_e          rsel;
   logic [IDX_W-1:0]   pidx;
   int unsigned        a_u;

   always_comb begin
      a_u  = 32'(addr);
      rsel = RS_NONE;
      pidx = '0;
      if (a_u == OFS_ROUTE)      rsel = RS_ROUTE;
      else if (a_u == OFS_MSET)  rsel = RS_MSET;
      else if (a_u == OFS_MCLR)  rsel = RS_MCLR;
      else if (a_u == OFS_BLOCK) rsel = RS_BLOCK;
      else if (a_u == OFS_SWSET) rsel = RS_SWSET;
      else if (a_u == OFS_SWCLR) rsel = RS_SWCLR;
      else if (a_u == OFS_IVEC)  rsel = RS_IVEC;
      else if (a_u == OFS_FVEC)  rsel = RS_FVEC;
      else if (a_u >= HW_LO && a_u < SW_LO && a_u[1:0] == 2'b00) begin
         rsel = RS_PHW;
         pidx = IDX_W'((a_u - HW_LO) >> 2);
      end
      else if (a_u >= SW_LO && a_u < SW_HI && a_u[1:0] == 2'b00) begin
         rsel = RS_PSW;
         pidx = IDX_W'((a_u - SW_LO) >> 2);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q   <= ROUTE_RST;
         mask_q    <= '1;
         sw_q      <= '0;
         block_q   <= '0;
         prio_hw_q <= '0;
         prio_sw_q <= '0;
      end else if (wr_en) begin
         case (rsel)
            RS_ROUTE: route_q         <= wdata[N_SRC-1:0];
            RS_MSET:  mask_q          <= mask_q | wdata[N_SRC-1:0];
            RS_MCLR:  mask_q          <= mask_q & ~wdata[N_SRC-1:0];
            RS_BLOCK: block_q         <= wdata[1:0];
            RS_SWSET: sw_q            <= sw_q | wdata[N_SRC-1:0];
            RS_SWCLR: sw_q            <= sw_q & ~wdata[N_SRC-1:0];
            RS_PHW:   prio_hw_q[pidx] <= wdata[PRIO_W-1:0];
            RS_PSW:   prio_sw_q[pidx] <= wdata[PRIO_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (rsel)
         RS_ROUTE:         rdata[N_SRC-1:0]  = route_q;
         RS_MSET, RS_MCLR: rdata[N_SRC-1:0]  = mask_q;
         RS_BLOCK:         rdata[1:0]        = block_q;
         RS_SWSET,
         RS_SWCLR:         rdata[N_SRC-1:0]  = sw_q;
         RS_IVEC:          rdata[VEC_W-1:0]  = irq_vec_i;
         RS_FVEC:          rdata[VEC_W-1:0]  = fiq_vec_i;
         RS_PHW:           rdata[PRIO_W-1:0] = prio_hw_q[pidx];
         RS_PSW:           rdata[PRIO_W-1:0] = prio_sw_q[pidx];
         default:          rdata = '0;
      endcase
   end
endmodule

// File: rtl/pic_arb.sv
module pic_arb
   import pic_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SRC-1:0]              cand_i,
   input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
   input  logic                          block_i,
   output logic [VEC_W-1:0]              vec_q
);
   localparam int unsigned IDX_W = $clog2(N_SRC);

   logic               found;
   logic [PRIO_W-1:0]  best_p;
   logic [IDX_W-1:0]   best_i;
   logic [VEC_W-1:0]   vec_d;

   // Downward scan with <=: an equal value further down replaces the
   // current pick, so the lowest line wins a tie.
   always_comb begin
      found  = 1'b0;
      best_p = '1;
      best_i = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (cand_i[i] && (!found || prio_i[i] <= best_p)) begin
            found  = 1'b1;
            best_p = prio_i[i];
            best_i = IDX_W'(i);
         end
      end
      vec_d = '0;
      if (found && !block_i) begin
         vec_d[IDX_W-1:0] = best_i;
         vec_d[VEC_ACT]   = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vec_q <= '0;
      else        vec_q <= vec_d;
   end
endmodule

// File: rtl/pic_prio_ctrl.sv
module pic_prio_ctrl
   import pic_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 5,
   parameter int unsigned ADDR_W = 9,
   parameter logic [N_SRC-1:0] ROUTE_RST = N_SRC'(32'h0FFF_FFFF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  hw_req,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int unsigned N_OUT = 2;

   if (N_SRC < 2 || N_SRC > 32) begin : g_bad_nsrc
      $error("pic_prio_ctrl: N_SRC must lie in 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > 32) begin : g_bad_prio
      $error("pic_prio_ctrl: PRIO_W must lie in 1..32");
   end
   if ((OFS_PHW + 8 * N_SRC) > (2 ** ADDR_W)) begin : g_bad_addr
      $error("pic_prio_ctrl: ADDR_W too narrow for priority window");
   end

   logic [N_SRC-1:0]                   route_q, mask_q, sw_q;
   logic [1:0]                         block_q;
   logic [N_SRC-1:0][PRIO_W-1:0]       prio_hw_q, prio_sw_q;
   logic [N_OUT-1:0][N_SRC-1:0]        cand;
   logic [N_OUT-1:0][N_SRC-1:0][PRIO_W-1:0] cprio;
   logic [N_OUT-1:0][VEC_W-1:0]        vec;

   pic_regs #(
      .N_SRC(N_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .ROUTE_RST(ROUTE_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .irq_vec_i (vec[0]),
      .fiq_vec_i (vec[1]),
      .rdata     (rdata),
      .route_q   (route_q),
      .mask_q    (mask_q),
      .sw_q      (sw_q),
      .block_q   (block_q),
      .prio_hw_q (prio_hw_q),
      .prio_sw_q (prio_sw_q)
   );

   // index 0 = IRQ path, index 1 = FIQ path
   for (genvar i = 0; i < N_SRC; i++) begin : g_line
      assign cand[0][i]  = !mask_q[i] && (route_q[i] ? hw_req[i] : sw_q[i]);
      assign cand[1][i]  = !mask_q[i] && (route_q[i] ? sw_q[i] : hw_req[i]);
      assign cprio[0][i] = route_q[i] ? prio_hw_q[i] : prio_sw_q[i];
      assign cprio[1][i] = route_q[i] ? prio_sw_q[i] : prio_hw_q[i];
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      pic_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
         .clk     (clk),
         .rst_n   (rst_n),
         .cand_i  (cand[o]),
         .prio_i  (cprio[o]),
         .block_i (block_q[o]),
         .vec_q   (vec[o])
      );
   end

   assign irq_o = vec[0][VEC_ACT];
   assign fiq_o = vec[1][VEC_ACT];
endmodule

// File: rtl/pic_prio_ctrl_chk.sv
module pic_prio_ctrl_chk #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [N_SRC-1:0]  wlow,
   input logic              irq_o,
   input logic              fiq_o,
   input logic [5:0]        irq_vec,
   input logic [5:0]        fiq_vec,
   input logic [1:0]        block_q,
   input logic [N_SRC-1:0]  mask_q,
   input logic [N_SRC-1:0]  sw_q,
   input logic [N_SRC-1:0]  cand_irq,
   input logic [N_SRC-1:0]  cand_fiq
);
   localparam int unsigned IDX_W = $clog2(N_SRC);

   AST_BLOCK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      block_q[0] |=> !irq_o); // R7
   AST_BLOCK_FIQ: assert property (@(posedge clk) disable iff (!rst_n)
      block_q[1] |=> !fiq_o); // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o |-> irq_vec == 6'd0) and (!fiq_o |-> fiq_vec == 6'd0)); // R8
   AST_IRQ_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> |($past(cand_irq) & (N_SRC'(1) << irq_vec[IDX_W-1:0]))); // R6
   AST_FIQ_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> |($past(cand_fiq) & (N_SRC'(1) << fiq_vec[IDX_W-1:0]))); // R5
   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(4)) |=> (mask_q & $past(wlow)) == $past(wlow)); // R2
   AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'('h14)) |=> (sw_q & $past(wlow)) == '0); // R9
endmodule

bind pic_prio_ctrl pic_prio_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wlow     (wdata[N_SRC-1:0]),
   .irq_o    (irq_o),
   .fiq_o    (fiq_o),
   .irq_vec  (vec[0]),
   .fiq_vec  (vec[1]),
   .block_q  (block_q),
   .mask_q   (mask_q),
   .sw_q     (sw_q),
   .cand_irq (cand[0]),
   .cand_fiq (cand[1])
);

// File: tb/pic_prio_ctrl_test.sv
module pic_prio_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hw_req = '0;
   logic        wr_en = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, fiq_o;
   int          n_run = 0, n_fail = 0;
   bit          done = 0;

   always #4 clk = ~clk;

   pic_prio_ctrl uut (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   typedef struct packed {
      logic [31:0] route, en, sw, hw;
      logic [5:0]  ei, ef;
   } vec_t;

   // hw prio: 16 except line5=3, line20=3, line30=1; sw prio: 16 except line2=0, line29=8
   localparam vec_t TBL [13] = '{
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,          6'h00, 6'h00},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h00000208,   6'h23, 6'h00},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h00100200,   6'h34, 6'h00},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h00100020,   6'h25, 6'h00},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h40000020,   6'h25, 6'h3E},
      '{32'h0FFFFFFF, 32'hFFFFFFDF, 32'h0,        32'h00100020,   6'h34, 6'h00},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h20000000, 32'h00000200,   6'h3D, 6'h00},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h00000004, 32'h80000000,   6'h00, 6'h22},
      '{32'h00000000, 32'hFFFFFFFF, 32'h0,        32'h40100000,   6'h00, 6'h3E},
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'hC0000000,   6'h3E, 6'h00},
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h20000004, 32'h0,          6'h00, 6'h22},
      '{32'h0FFFFFFF, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF,   6'h25, 6'h3E},
      '{32'h0FFFFFFF, 32'h00000000, 32'h0,        32'hFFFFFFFF,   6'h00, 6'h00}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic apply(input vec_t v);
      wr(9'h00, v.route);
      wr(9'h04, 32'hFFFFFFFF);
      wr(9'h08, v.en);
      wr(9'h14, 32'hFFFFFFFF);
      wr(9'h10, v.sw);
      hw_req = v.hw;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(9'h00, d); chk("R1 route reset", d, 32'h0FFFFFFF);
      rd(9'h04, d); chk("R1 mask reset", d, 32'hFFFFFFFF);
      rd(9'h10, d); chk("R1 sw reset", d, 32'h0);
      rd(9'h0C, d); chk("R1 block reset", d, 32'h0);
      rd(9'h5C, d); chk("R1 prio reset", d, 32'h0);
      hw_req = '1; settle();
      chk("R1 outputs low while masked", {30'b0, fiq_o, irq_o}, 32'h0);
      hw_req = '0;

      for (int i = 0; i < 32; i++) begin
         wr(9'(32'h40 + 4 * i), 32'd16);
         wr(9'(32'hC0 + 4 * i), 32'd16);
      end
      wr(9'h54, 32'd3);  wr(9'h90, 32'd3);  wr(9'hB8, 32'd1);
      wr(9'hC8, 32'd0);  wr(9'h134, 32'd8);

      // R3 priority readback and width
      rd(9'h90, d);  chk("R3 hw prio line20", d, 32'd3);
      rd(9'h134, d); chk("R3 sw prio line29", d, 32'd8);
      wr(9'h40, 32'hFFFFFFE7);
      rd(9'h40, d);  chk("R3 prio truncation", d, 32'd7);
      wr(9'h40, 32'd16);
      rd(9'h3C, d);  chk("R10 unmapped read", d, 32'h0);

      // table of routing / mask / tie patterns (R4 R5 R6 R8)
      for (int k = 0; k < 13; k++) begin
         apply(TBL[k]);
         settle();
         rd(9'h18, d); chk($sformatf("R4/R5/R6 irq vec row %0d", k), d, {26'b0, TBL[k].ei});
         rd(9'h1C, d); chk($sformatf("R5/R6 fiq vec row %0d", k), d, {26'b0, TBL[k].ef});
         chk($sformatf("R8 pins row %0d", k), {30'b0, fiq_o, irq_o},
             {30'b0, TBL[k].ef[5], TBL[k].ei[5]});
      end

      // R7 block bits
      apply(TBL[4]); settle();
      wr(9'h18, 32'h0);
      rd(9'h18, d); chk("R10 vector write ignored", d, 32'h25);
      wr(9'h0C, 32'h1); settle();
      rd(9'h18, d); chk("R7 irq blocked vec", d, 32'h0);
      chk("R7 irq pin low", {31'b0, irq_o}, 32'h0);
      rd(9'h1C, d); chk("R7 fiq unaffected", d, 32'h3E);
      rd(9'h04, d); chk("R7 masks unchanged", d, 32'h0);
      rd(9'h0C, d); chk("R7 block readback", d, 32'h1);
      wr(9'h0C, 32'h2); settle();
      rd(9'h18, d); chk("R7 irq released", d, 32'h25);
      rd(9'h1C, d); chk("R7 fiq blocked", d, 32'h0);
      wr(9'h0C, 32'h0);

      // R9 level hw, sticky sw
      hw_req = '0; settle();
      chk("R9 hw level drop", {30'b0, fiq_o, irq_o}, 32'h0);
      wr(9'h10, 32'h20000000); settle();
      rd(9'h18, d); chk("R9 sw request raises", d, 32'h3D);
      wr(9'h00, 32'h0FFFFFFF); wr(9'h0C, 32'h0); settle();
      rd(9'h10, d); chk("R9 sw sticky", d, 32'h20000000);
      rd(9'h18, d); chk("R9 sw still active", d, 32'h3D);
      wr(9'h14, 32'h20000000); settle();
      rd(9'h10, d); chk("R9 sw cleared", d, 32'h0);
      chk("R9 irq drops after clear", {31'b0, irq_o}, 32'h0);

      // R8 one-edge latency
      @(negedge clk);
      hw_req = 32'h8;
      #1 chk("R8 before edge", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R8 after one edge", {31'b0, irq_o}, 32'h1);

      done = 1;
      summary();
      $finish;
   end
endmodule